// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative translation cache. It maps virtual page numbers to physical page numbers. Every slot carries an address-space tag, a global flag, a physical page number, per-privilege-mode read and write enable masks, and two fault-on-access flags. A lookup compares the requested page and address space against every slot at once. One cycle later it returns a hit flag, the slot index and the stored fields. Permission evaluation and fault generation are left to the consumer of those fields.

Refill is software-managed. A single replacement pointer names the slot that the next insert overwrites, and a read port always shows the contents of that slot. The pointer can be stepped without writing. Three invalidation commands are provided: every slot, every non-global slot, and the slots that match one page within one address space.

Top module: `pgmap_tlb`

## Requirements
- R1: A slot matches a lookup only when it is valid, its page tag equals `lk_vpn`, and either its global flag is set or its address-space tag equals `lk_asn`. At most one slot may match a lookup; if several do, the lowest index is reported.
- R2: `lk_done` is high in exactly the cycle after a cycle with `lk_req` high, and low otherwise.
- R3: On a hit, `lk_hit` is 1 and `lk_slot`, `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_fault_rd`, `lk_fault_wr` and `lk_global` show the matching slot. On a miss, `lk_hit` is 0.
- R4: With `op_code` = 1 (insert), the slot at the replacement pointer is written with `op_vpn`, `op_asn` and the `ins_*` fields and made valid. The pointer then advances by one and wraps from 15 to 0.
- R5: An insert fully replaces the old contents of its slot, so the previous mapping of that slot no longer hits.
- R6: `op_code` = 2 invalidates every slot and returns the replacement pointer to 0.
- R7: `op_code` = 3 invalidates every slot whose global flag is clear and leaves global slots valid.
- R8: `op_code` = 4 invalidates every slot whose tag equals `op_vpn` and which is global or has address-space tag `op_asn`. All other slots are unaffected.
- R9: A lookup issued in the same cycle as an insert or invalidation sees the contents from before that command.
- R10: `vic_adv` high steps the replacement pointer by one without writing a slot. It is ignored with `op_code` 1 or 2. The `vic_*` outputs always show the slot at the pointer.
- R11: After reset, every slot is invalid, the pointer is 0, and `lk_done` and `lk_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 30 | Virtual page number to translate |
| lk_asn | input | 8 | Address space of the lookup |
| op_code | input | 3 | 0 idle, 1 insert, 2 invalidate all, 3 invalidate non-global, 4 invalidate page |
| op_vpn | input | 30 | Page for insert or page invalidation |
| op_asn | input | 8 | Address space for insert or page invalidation |
| ins_ppn | input | 27 | Physical page number to insert |
| ins_global | input | 1 | Global flag to insert |
| ins_rd_en | input | 4 | Read-enable mask, one bit per privilege mode |
| ins_wr_en | input | 4 | Write-enable mask, one bit per privilege mode |
| ins_fault_rd | input | 1 | Fault-on-read flag to insert |
| ins_fault_wr | input | 1 | Fault-on-write flag to insert |
| vic_adv | input | 1 | Step the replacement pointer without writing |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_slot | output | 4 | Index of the hitting slot |
| lk_ppn | output | 27 | Physical page number of the hit |
| lk_rd_en | output | 4 | Read-enable mask of the hit |
| lk_wr_en | output | 4 | Write-enable mask of the hit |
| lk_fault_rd | output | 1 | Fault-on-read flag of the hit |
| lk_fault_wr | output | 1 | Fault-on-write flag of the hit |
| lk_global | output | 1 | Global flag of the hit |
| vic_idx | output | 4 | Replacement pointer |
| vic_valid | output | 1 | Valid bit of the slot at the pointer |
| vic_vpn | output | 30 | Tag of the slot at the pointer |
| vic_asn | output | 8 | Address-space tag of the slot at the pointer |
| vic_global | output | 1 | Global flag of the slot at the pointer |
| vic_ppn | output | 27 | Physical page of the slot at the pointer |

## Verification
The bound checker watches properties on every cycle:
- no lookup ever sees two matching slots;
- the result strobe follows the request by exactly one cycle;
- each insert makes its slot valid and steps the pointer with wrap;
- a full invalidation empties the table and zeroes the pointer;
- a non-global invalidation leaves exactly the global slots that were valid before.

Some behaviour only the bench scenarios can show, because it needs a model of the table contents:
- the address-space rule, including global slots hitting under a foreign address space;
- the stored fields returned on a hit;
- eviction of the old mapping on wrap-around;
- the selective page invalidation;
- lookups in the same cycle as a command seeing the old contents;
- the replacement read port.

// File: rtl/pgmap_tlb_pkg.sv
`timescale 1ns/1ps
package pgmap_tlb_pkg;

  typedef enum logic [2:0] {
    OP_IDLE       = 3'd0,
    OP_INSERT     = 3'd1,
    OP_FLUSH_ALL  = 3'd2,
    OP_FLUSH_PROC = 3'd3,
    OP_FLUSH_PAGE = 3'd4
  } tlb_op_e;

endpackage

// File: rtl/pgmap_tlb_match.sv
`timescale 1ns/1ps
// Parallel tag/address-space comparator across all slots.
module pgmap_tlb_match #(
  parameter int N     = 16,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8
) (
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     glob_vec,
  input  logic [VPN_W-1:0] tag_arr [N],
  input  logic [ASN_W-1:0] asn_arr [N],
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [ASN_W-1:0] q_asn,
  output logic [N-1:0]     match_vec
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic tag_eq;
    logic asn_ok;
    assign tag_eq       = (tag_arr[i] == q_vpn);
    assign asn_ok       = glob_vec[i] || (asn_arr[i] == q_asn);
    assign match_vec[i] = valid_vec[i] && tag_eq && asn_ok;
  end

endmodule

// File: rtl/pgmap_tlb_prio.sv
`timescale 1ns/1ps
// Lowest-index priority encoder.
module pgmap_tlb_prio #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/pgmap_tlb_victim.sv
`timescale 1ns/1ps
// Round-robin replacement pointer.
module pgmap_tlb_victim #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)  ptr <= '0;
    else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/pgmap_tlb.sv
`timescale 1ns/1ps
module pgmap_tlb
  import pgmap_tlb_pkg::*;
#(
  parameter int N       = 16,
  parameter int VPN_W   = 30,
  parameter int PPN_W   = 27,
  parameter int ASN_W   = 8,
  parameter int MODES   = 4,
  parameter int IDX_W   = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  input  logic [2:0]       op_code,
  input  logic [VPN_W-1:0] op_vpn,
  input  logic [ASN_W-1:0] op_asn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic             ins_global,
  input  logic [MODES-1:0] ins_rd_en,
  input  logic [MODES-1:0] ins_wr_en,
  input  logic             ins_fault_rd,
  input  logic             ins_fault_wr,
  input  logic             vic_adv,
  output logic             lk_done,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_slot,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [MODES-1:0] lk_rd_en,
  output logic [MODES-1:0] lk_wr_en,
  output logic             lk_fault_rd,
  output logic             lk_fault_wr,
  output logic             lk_global,
  output logic [IDX_W-1:0] vic_idx,
  output logic             vic_valid,
  output logic [VPN_W-1:0] vic_vpn,
  output logic [ASN_W-1:0] vic_asn,
  output logic             vic_global,
  output logic [PPN_W-1:0] vic_ppn
);

  tlb_op_e op;
  assign op = tlb_op_e'(op_code);

  // Slot state: valid and global bits reset; payload arrays do not.
  logic [N-1:0]     valid_vec;
  logic [N-1:0]     glob_vec;
  logic [N-1:0]     frd_vec;
  logic [N-1:0]     fwr_vec;
  logic [VPN_W-1:0] tag_arr [N];
  logic [ASN_W-1:0] asn_arr [N];
  logic [PPN_W-1:0] ppn_arr [N];
  logic [MODES-1:0] rd_arr  [N];
  logic [MODES-1:0] wr_arr  [N];

  logic [IDX_W-1:0] ptr;
  logic [N-1:0]     lk_match_vec;
  logic [N-1:0]     fl_match_vec;
  logic             lk_any;
  logic [IDX_W-1:0] lk_idx;
  logic             do_insert;
  logic             ptr_clr;
  logic             ptr_adv;

  assign do_insert = (op == OP_INSERT);
  assign ptr_clr   = (op == OP_FLUSH_ALL);
  assign ptr_adv   = do_insert || (vic_adv && !ptr_clr);

  pgmap_tlb_match #(.N(N), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
    .valid_vec (valid_vec),
    .glob_vec  (glob_vec),
    .tag_arr   (tag_arr),
    .asn_arr   (asn_arr),
    .q_vpn     (lk_vpn),
    .q_asn     (lk_asn),
    .match_vec (lk_match_vec)
  );

  pgmap_tlb_match #(.N(N), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
    .valid_vec (valid_vec),
    .glob_vec  (glob_vec),
    .tag_arr   (tag_arr),
    .asn_arr   (asn_arr),
    .q_vpn     (op_vpn),
    .q_asn     (op_asn),
    .match_vec (fl_match_vec)
  );

  pgmap_tlb_prio #(.N(N), .IDX_W(IDX_W)) u_prio (
    .req (lk_match_vec),
    .any (lk_any),
    .idx (lk_idx)
  );

  pgmap_tlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .clk (clk),
    .rst (rst),
    .clr (ptr_clr),
    .adv (ptr_adv),
    .ptr (ptr)
  );

  // Valid bits: insert overwrites the pointed slot in one edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_vec <= '0;
    end else begin
      unique case (op)
        OP_INSERT:     valid_vec[ptr] <= 1'b1;
        OP_FLUSH_ALL:  valid_vec <= '0;
        OP_FLUSH_PROC: valid_vec <= valid_vec & glob_vec;
        OP_FLUSH_PAGE: valid_vec <= valid_vec & ~fl_match_vec;
        default:       valid_vec <= valid_vec;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_vec <= '0;
    end else if (do_insert) begin
      glob_vec[ptr] <= ins_global;
    end
  end

  // Payload storage: written only by insert, no reset.
  always_ff @(posedge clk) begin
    if (do_insert) begin
      tag_arr[ptr] <= op_vpn;
      asn_arr[ptr] <= op_asn;
      ppn_arr[ptr] <= ins_ppn;
      rd_arr[ptr]  <= ins_rd_en;
      wr_arr[ptr]  <= ins_wr_en;
      frd_vec[ptr] <= ins_fault_rd;
      fwr_vec[ptr] <= ins_fault_wr;
    end
  end

  // Registered lookup result from pre-update contents.
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
    end else begin
      lk_done <= lk_req;
      lk_hit  <= lk_req && lk_any;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_req) begin
      lk_slot     <= lk_idx;
      lk_ppn      <= ppn_arr[lk_idx];
      lk_rd_en    <= rd_arr[lk_idx];
      lk_wr_en    <= wr_arr[lk_idx];
      lk_fault_rd <= frd_vec[lk_idx];
      lk_fault_wr <= fwr_vec[lk_idx];
      lk_global   <= glob_vec[lk_idx];
    end
  end

  // Replacement-slot read port.
  assign vic_idx    = ptr;
  assign vic_valid  = valid_vec[ptr];
  assign vic_vpn    = tag_arr[ptr];
  assign vic_asn    = asn_arr[ptr];
  assign vic_global = glob_vec[ptr];
  assign vic_ppn    = ppn_arr[ptr];

endmodule

// File: rtl/pgmap_tlb_chk.sv
`timescale 1ns/1ps
module pgmap_tlb_chk #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       op_code,
  input logic             lk_req,
  input logic             lk_done,
  input logic             lk_hit,
  input logic [N-1:0]     valid_vec,
  input logic [N-1:0]     glob_vec,
  input logic [N-1:0]     lk_match_vec,
  input logic [IDX_W-1:0] ptr
);

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d === 1'b1 && rst === 1'b0) begin
      assert_reset_state_R11: assert (valid_vec == '0 && ptr == '0 && !lk_done && !lk_hit);
    end
  end

  assert_single_match_R1: assert property (@(posedge clk) disable iff (rst)
    lk_req |-> $countones(lk_match_vec) <= 1);

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_done);

  assert_done_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_done);

  assert_hit_with_done_R3: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_done);

  assert_insert_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd1) |=> valid_vec[$past(ptr)]);

  assert_insert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd1) |=> ptr == step_idx($past(ptr)));

  assert_flush_all_R6: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd2) |=> (valid_vec == '0 && ptr == '0));

  assert_flush_proc_R7: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd3) |=> valid_vec == ($past(valid_vec) & $past(glob_vec)));

endmodule

bind pgmap_tlb pgmap_tlb_chk #(.N(N), .IDX_W(IDX_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .op_code      (op_code),
  .lk_req       (lk_req),
  .lk_done      (lk_done),
  .lk_hit       (lk_hit),
  .valid_vec    (valid_vec),
  .glob_vec     (glob_vec),
  .lk_match_vec (lk_match_vec),
  .ptr          (ptr)
);

// File: tb/pgmap_tlb_tb_top.sv
`timescale 1ns/1ps
module pgmap_tlb_tb_top;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0;
  logic [29:0] lk_vpn = '0;
  logic [7:0]  lk_asn = '0;
  logic [2:0]  op_code = '0;
  logic [29:0] op_vpn = '0;
  logic [7:0]  op_asn = '0;
  logic [26:0] ins_ppn = '0;
  logic        ins_global = 1'b0;
  logic [3:0]  ins_rd_en = '0;
  logic [3:0]  ins_wr_en = '0;
  logic        ins_fault_rd = 1'b0;
  logic        ins_fault_wr = 1'b0;
  logic        vic_adv = 1'b0;

  logic        lk_done, lk_hit, lk_fault_rd, lk_fault_wr, lk_global;
  logic [3:0]  lk_slot, lk_rd_en, lk_wr_en, vic_idx;
  logic [26:0] lk_ppn, vic_ppn;
  logic        vic_valid, vic_global;
  logic [29:0] vic_vpn;
  logic [7:0]  vic_asn;

  always #2.5 clk = ~clk;

  pgmap_tlb dut_i (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
    .op_code(op_code), .op_vpn(op_vpn), .op_asn(op_asn), .ins_ppn(ins_ppn),
    .ins_global(ins_global), .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
    .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr), .vic_adv(vic_adv),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_ppn(lk_ppn),
    .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en), .lk_fault_rd(lk_fault_rd),
    .lk_fault_wr(lk_fault_wr), .lk_global(lk_global), .vic_idx(vic_idx),
    .vic_valid(vic_valid), .vic_vpn(vic_vpn), .vic_asn(vic_asn),
    .vic_global(vic_global), .vic_ppn(vic_ppn)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference table built from the requirements.
  bit          m_valid [N];
  bit          m_glob  [N];
  logic [29:0] m_vpn   [N];
  logic [7:0]  m_asn   [N];
  logic [26:0] m_ppn   [N];
  logic [3:0]  m_rd    [N];
  logic [3:0]  m_wr    [N];
  bit          m_frd   [N];
  bit          m_fwr   [N];
  int          m_ptr = 0;

  typedef struct {
    bit          hit;
    logic [3:0]  slot;
    logic [26:0] ppn;
    logic [3:0]  rd, wr;
    bit          frd, fwr, glob;
    string       tag;
  } exp_t;

  exp_t scb[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model_lookup(input logic [29:0] v, input logic [7:0] a,
                                        input string tag);
    exp_t e;
    e.hit = 0; e.slot = '0; e.ppn = '0; e.rd = '0; e.wr = '0;
    e.frd = 0; e.fwr = 0; e.glob = 0; e.tag = tag;
    for (int i = 0; i < N; i++) begin
      if (!e.hit && m_valid[i] && m_vpn[i] == v && (m_glob[i] || m_asn[i] == a)) begin
        e.hit = 1; e.slot = 4'(i); e.ppn = m_ppn[i]; e.rd = m_rd[i]; e.wr = m_wr[i];
        e.frd = m_frd[i]; e.fwr = m_fwr[i]; e.glob = m_glob[i];
      end
    end
    return e;
  endfunction

  // Driver: one cycle, called at a falling edge.
  task automatic step(input logic [2:0] op, input logic [29:0] ov, input logic [7:0] oa,
                      input logic [26:0] pp, input bit gl, input logic [3:0] rd,
                      input logic [3:0] wr, input bit fr, input bit fw, input bit adv,
                      input bit lreq, input logic [29:0] lv, input logic [7:0] la,
                      input string tag);
    if (lreq) scb.push_back(model_lookup(lv, la, tag));
    op_code = op; op_vpn = ov; op_asn = oa; ins_ppn = pp; ins_global = gl;
    ins_rd_en = rd; ins_wr_en = wr; ins_fault_rd = fr; ins_fault_wr = fw;
    vic_adv = adv; lk_req = lreq; lk_vpn = lv; lk_asn = la;
    case (op)
      3'd1: begin
        m_valid[m_ptr] = 1; m_glob[m_ptr] = gl; m_vpn[m_ptr] = ov; m_asn[m_ptr] = oa;
        m_ppn[m_ptr] = pp; m_rd[m_ptr] = rd; m_wr[m_ptr] = wr;
        m_frd[m_ptr] = fr; m_fwr[m_ptr] = fw;
        m_ptr = (m_ptr + 1) % N;
      end
      3'd2: begin
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        m_ptr = 0;
      end
      3'd3: for (int i = 0; i < N; i++) if (!m_glob[i]) m_valid[i] = 0;
      3'd4: for (int i = 0; i < N; i++)
              if (m_vpn[i] == ov && (m_glob[i] || m_asn[i] == oa)) m_valid[i] = 0;
      default: ;
    endcase
    if (adv && op != 3'd1 && op != 3'd2) m_ptr = (m_ptr + 1) % N;
    @(negedge clk);
    op_code = 3'd0; vic_adv = 0; lk_req = 0;
  endtask

  task automatic ins(input logic [29:0] v, input logic [7:0] a, input logic [26:0] p,
                     input bit g);
    step(3'd1, v, a, p, g, p[3:0], ~p[3:0], p[4], p[5], 0, 0, '0, '0, "");
  endtask

  task automatic flush(input logic [2:0] op, input logic [29:0] v, input logic [7:0] a);
    step(op, v, a, '0, 0, '0, '0, 0, 0, 0, 0, '0, '0, "");
  endtask

  task automatic look(input logic [29:0] v, input logic [7:0] a, input string tag);
    step(3'd0, '0, '0, '0, 0, '0, '0, 0, 0, 0, 1, v, a, tag);
  endtask

  // Monitor: samples one time unit after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        if (lk_done) begin
          if (scb.size() == 0) begin
            check(0, "R2", "unexpected lk_done", 1, 0);
          end else begin
            exp_t e;
            e = scb.pop_front();
            check(lk_hit == e.hit, e.tag, "lk_hit", lk_hit, e.hit);
            if (e.hit && lk_hit) begin
              check(lk_slot == e.slot && lk_ppn == e.ppn && lk_rd_en == e.rd &&
                    lk_wr_en == e.wr && lk_fault_rd == e.frd &&
                    lk_fault_wr == e.fwr && lk_global == e.glob,
                    "R3", "hit fields (ppn shown)", lk_ppn, e.ppn);
            end
          end
        end else if (scb.size() != 0) begin
          check(0, "R2", "lk_done missing", 0, 1);
        end
      end
    end
  end

  task automatic vic_check(input string tag);
    check(vic_idx == 4'(m_ptr), tag, "vic_idx", vic_idx, m_ptr);
    check(vic_valid == m_valid[m_ptr], tag, "vic_valid", vic_valid, m_valid[m_ptr]);
    if (m_valid[m_ptr])
      check(vic_vpn == m_vpn[m_ptr] && vic_ppn == m_ppn[m_ptr] &&
            vic_asn == m_asn[m_ptr] && vic_global == m_glob[m_ptr],
            tag, "vic fields (vpn shown)", vic_vpn, m_vpn[m_ptr]);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_glob[i] = 0; m_vpn[i] = '0; m_asn[i] = '0; m_ppn[i] = '0;
      m_rd[i] = '0; m_wr[i] = '0; m_frd[i] = 0; m_fwr[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: reset state
    check(lk_done == 0, "R11", "lk_done", lk_done, 0);
    check(lk_hit == 0, "R11", "lk_hit", lk_hit, 0);
    check(vic_idx == 0, "R11", "vic_idx", vic_idx, 0);
    check(vic_valid == 0, "R11", "vic_valid", vic_valid, 0);
    look(30'h10, 8'd1, "R11");

    // R1/R3: address-space rule, global entries
    ins(30'h10, 8'd1, 27'h0abc1, 0);
    ins(30'h20, 8'd2, 27'h0abc2, 1);
    ins(30'h30, 8'd3, 27'h0abc3, 0);
    look(30'h10, 8'd1, "R1");
    look(30'h10, 8'd9, "R1");
    look(30'h20, 8'd7, "R1");
    look(30'h30, 8'd3, "R3");
    look(30'h31, 8'd3, "R3");
    vic_check("R4");

    // R9: same-cycle lookup sees old contents
    step(3'd1, 30'h40, 8'd4, 27'h0abc4, 0, 4'h3, 4'h1, 0, 1, 0, 1, 30'h40, 8'd4, "R9");
    look(30'h40, 8'd4, "R9");
    step(3'd4, 30'h10, 8'd1, '0, 0, '0, '0, 0, 0, 0, 1, 30'h10, 8'd1, "R9");
    look(30'h10, 8'd1, "R8");

    // R8: page invalidation respects address space
    ins(30'h50, 8'd5, 27'h0abc5, 0);
    flush(3'd4, 30'h50, 8'd6);
    look(30'h50, 8'd5, "R8");
    flush(3'd4, 30'h20, 8'd99);
    look(30'h20, 8'd2, "R8");

    // R7: non-global invalidation
    ins(30'h60, 8'd6, 27'h0abc6, 1);
    ins(30'h70, 8'd7, 27'h0abc7, 0);
    flush(3'd3, '0, '0);
    look(30'h60, 8'd1, "R7");
    look(30'h70, 8'd7, "R7");
    look(30'h30, 8'd3, "R7");

    // R6: invalidate all
    flush(3'd2, '0, '0);
    check(vic_idx == 0, "R6", "vic_idx", vic_idx, 0);
    check(vic_valid == 0, "R6", "vic_valid", vic_valid, 0);
    look(30'h60, 8'd1, "R6");

    // R4/R5: fill, wrap, overwrite
    for (int i = 0; i < N; i++) ins(30'h100 + 30'(i), 8'd5, 27'h1000 + 27'(i), (i % 4) == 0);
    check(vic_idx == 0, "R4", "wrap vic_idx", vic_idx, 0);
    look(30'h107, 8'd5, "R4");
    look(30'h10f, 8'd5, "R4");
    look(30'h104, 8'd77, "R1");
    ins(30'h200, 8'd5, 27'h2000, 0);
    look(30'h100, 8'd5, "R5");
    look(30'h200, 8'd5, "R5");
    vic_check("R4");

    // R10: pointer step without write, ignored with insert/flush-all
    step(3'd0, '0, '0, '0, 0, '0, '0, 0, 0, 1, 0, '0, '0, "");
    vic_check("R10");
    step(3'd0, '0, '0, '0, 0, '0, '0, 0, 0, 1, 0, '0, '0, "");
    vic_check("R10");
    look(30'h102, 8'd5, "R10");
    step(3'd1, 30'h300, 8'd8, 27'h3000, 0, 4'hf, 4'h0, 1, 0, 1, 0, '0, '0, "");
    vic_check("R10");
    look(30'h300, 8'd8, "R10");
    step(3'd2, '0, '0, '0, 0, '0, '0, 0, 0, 1, 0, '0, '0, "");
    vic_check("R10");

    repeat (3) @(negedge clk);
    check(scb.size() == 0, "R2", "pending results", scb.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule